// File: doc/BRIEF.md
# Power-Off Acknowledge Timeout Controller

This block sits in a root-complex port and closes out the handshake that comes before power is removed from the link partner. Once the turn-off message has gone downstream, software logic raises a one-cycle strobe. The block then waits for one of two events. The first is an acknowledge pulse from the downstream device. The second is the expiry of a programmable count of core clock cycles. Whichever event comes first, the block raises a level that says power may now be switched off.

Expiry of the count is not treated as a fault. Both endings grant permission to power off, and two status bits record which ending occurred. A 32-bit register-write port holds the count. Software computes that count as the wanted delay in microseconds multiplied by the core clock in MHz, and the block uses the value unchanged. The 22-bit field covers delays of 1 ms to 10 ms at the usual core rates. The function is only active when the mode input selects root-complex operation.

Top module: `pwroff_ack_timer`

## Requirements
- R1: After synchronous reset, `safe_off`, `st_acked`, `st_timeout` and `waiting` are 0, and `reg_rdata` reads 0.
- R2: A write on `reg_wr` stores `reg_wdata[21:0]` as the count; bits 31:22 of `reg_rdata` always read 0 and writes to them are discarded.
- R3: With `rc_mode`=1, a `turnoff_sent` pulse sampled while idle or done sets `waiting`=1 and clears `safe_off`, `st_acked` and `st_timeout` at the next edge.
- R4: With count N and no acknowledge, `st_timeout` and `safe_off` rise, and `waiting` falls, N+1 clock edges after the edge that sampled the strobe; N=0 gives one edge.
- R5: An `ack_rcvd` pulse sampled while waiting ends the wait at that edge, setting `st_acked`=1 and `safe_off`=1.
- R6: When an acknowledge and count expiry fall on the same edge, the acknowledge wins: `st_acked`=1 and `st_timeout`=0.
- R7: After the wait ends, `safe_off` and the status bits hold until `sw_clear` returns the block to idle with all three at 0, or until a new strobe starts another wait.
- R8: With `rc_mode`=0, `turnoff_sent` is ignored and no wait starts.
- R9: `ack_rcvd` outside a wait changes neither `safe_off` nor the status bits.
- R10: A register write during a wait does not change that wait's length; the new count applies from the next strobe.
- R11: `turnoff_sent` and `sw_clear` during a wait are ignored and the wait ends at its original time.
- R12: A strobe and `sw_clear` on the same edge after the wait has ended start a new wait.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| rc_mode | input | 1 | 1 selects root-complex operation |
| reg_wr | input | 1 | Count register write strobe |
| reg_wdata | input | 32 | Count register write data |
| reg_rdata | output | 32 | Count register read value |
| turnoff_sent | input | 1 | One-cycle pulse: turn-off message broadcast |
| ack_rcvd | input | 1 | One-cycle pulse: acknowledge message received |
| sw_clear | input | 1 | Returns a finished handshake to idle |
| safe_off | output | 1 | Power may be removed |
| st_acked | output | 1 | Handshake ended by acknowledge |
| st_timeout | output | 1 | Handshake ended by count expiry |
| waiting | output | 1 | Handshake in progress |

## Verification
Two of the block's functions can fall on the same edge: an acknowledge arrival and count expiry. The bench makes them coincide by sweeping the acknowledge offset over every cycle of each wait for small counts. This includes the offset N+1, where the counter reads zero as the acknowledge is sampled. Every outcome is judged against the arithmetic rule: an acknowledge at offset j ≤ N+1 ends the wait at j with the acked bit set, and any later acknowledge leaves a timeout at N+1.

// File: rtl/poa_pkg.sv
package poa_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_DONE = 2'd2
  } poa_state_t;
endpackage

// File: rtl/poa_limit_reg.sv
module poa_limit_reg #(
  parameter int REG_W   = 32,
  parameter int CNT_W   = 22,
  parameter int RST_VAL = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wdata,
  output logic [CNT_W-1:0] limit,
  output logic [REG_W-1:0] rdata
);
  localparam int PAD_W = REG_W - CNT_W;

  always_ff @(posedge clk) begin
    if (rst)        limit <= CNT_W'(RST_VAL);
    else if (wr_en) limit <= wdata[CNT_W-1:0];
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign rdata = {{PAD_W{1'b0}}, limit};
    end else begin : g_nopad
      assign rdata = limit;
    end
  endgenerate

  AST_REG_LOAD: assert property (@(posedge clk) disable iff (rst)
    wr_en |=> (limit == $past(wdata[CNT_W-1:0]))); // R2
endmodule

// File: rtl/poa_countdown.sv
module poa_countdown #(
  parameter int CNT_W = 22
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             cnt_zero
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                   cnt <= '0;
    else if (load)             cnt <= load_val;
    else if (run && !cnt_zero) cnt <= cnt - CNT_W'(1);
  end

  assign cnt_zero = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && !cnt_zero) |=> (cnt == $past(cnt) - CNT_W'(1))); // R4
  AST_CNT_LOAD: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(load_val))); // R10
endmodule

// File: rtl/poa_fsm.sv
module poa_fsm
  import poa_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic rc_mode,
  input  logic turnoff,
  input  logic ack,
  input  logic sw_clear,
  input  logic cnt_zero,
  output logic load,
  output logic run,
  output logic safe_off,
  output logic st_acked,
  output logic st_timeout,
  output logic waiting
);
  poa_state_t state;
  logic       start;

  assign start = turnoff && rc_mode && (state != ST_WAIT);
  assign load  = start;
  assign run   = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      safe_off   <= 1'b0;
      st_acked   <= 1'b0;
      st_timeout <= 1'b0;
      waiting    <= 1'b0;
    end else begin
      case (state)
        ST_WAIT: begin
          if (ack || cnt_zero) begin
            state      <= ST_DONE;
            waiting    <= 1'b0;
            safe_off   <= 1'b1;
            st_acked   <= ack;
            st_timeout <= !ack;
          end
        end
        default: begin
          if (start) begin
            state      <= ST_WAIT;
            waiting    <= 1'b1;
            safe_off   <= 1'b0;
            st_acked   <= 1'b0;
            st_timeout <= 1'b0;
          end else if (sw_clear && state == ST_DONE) begin
            state      <= ST_IDLE;
            safe_off   <= 1'b0;
            st_acked   <= 1'b0;
            st_timeout <= 1'b0;
          end
        end
      endcase
    end
  end

  AST_EP_IGNORE: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && turnoff && !rc_mode) |=> (state == ST_IDLE)); // R8
  AST_ACK_WINS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && ack) |=> (st_acked && !st_timeout && safe_off)); // R6
  AST_STATUS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $onehot0({st_acked, st_timeout})); // R4
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (state == ST_DONE && !turnoff && !sw_clear) |=>
      ($stable(st_acked) && $stable(st_timeout) && safe_off)); // R9
  AST_NO_EARLY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && !ack && !cnt_zero) |=> waiting); // R11
endmodule

// File: rtl/pwroff_ack_timer.sv
module pwroff_ack_timer #(
  parameter int REG_W     = 32,
  parameter int CNT_W     = 22,
  parameter int LIMIT_RST = 0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             rc_mode,
  input  logic             reg_wr,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             turnoff_sent,
  input  logic             ack_rcvd,
  input  logic             sw_clear,
  output logic             safe_off,
  output logic             st_acked,
  output logic             st_timeout,
  output logic             waiting
);
  logic [CNT_W-1:0] limit;
  logic             load;
  logic             run;
  logic             cnt_zero;

  poa_limit_reg #(.REG_W(REG_W), .CNT_W(CNT_W), .RST_VAL(LIMIT_RST)) u_limit (
    .clk(clk), .rst(rst), .wr_en(reg_wr), .wdata(reg_wdata),
    .limit(limit), .rdata(reg_rdata)
  );

  poa_countdown #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst(rst), .load(load), .load_val(limit),
    .run(run), .cnt_zero(cnt_zero)
  );

  poa_fsm u_fsm (
    .clk(clk), .rst(rst), .rc_mode(rc_mode), .turnoff(turnoff_sent),
    .ack(ack_rcvd), .sw_clear(sw_clear), .cnt_zero(cnt_zero),
    .load(load), .run(run), .safe_off(safe_off), .st_acked(st_acked),
    .st_timeout(st_timeout), .waiting(waiting)
  );

  AST_SAFE_STATUS: assert property (@(posedge clk) disable iff (rst)
    safe_off == (st_acked || st_timeout)); // R7
  AST_WAIT_NOT_SAFE: assert property (@(posedge clk) disable iff (rst)
    waiting |-> !safe_off); // R3
endmodule

// File: tb/test_pwroff_ack_timer.sv
`timescale 1ns/1ps
module test_pwroff_ack_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        rc_mode = 1'b1;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        turnoff_sent = 1'b0;
  logic        ack_rcvd = 1'b0;
  logic        sw_clear = 1'b0;
  logic        safe_off, st_acked, st_timeout, waiting;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pwroff_ack_timer i_pwroff_ack_timer (
    .clk(clk), .rst(rst), .rc_mode(rc_mode), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .turnoff_sent(turnoff_sent), .ack_rcvd(ack_rcvd), .sw_clear(sw_clear),
    .safe_off(safe_off), .st_acked(st_acked), .st_timeout(st_timeout),
    .waiting(waiting)
  );

  task automatic check(input string req, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr_limit(input logic [31:0] v);
    reg_wr = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic strobe();
    turnoff_sent = 1'b1;
    @(negedge clk);
    turnoff_sent = 1'b0;
  endtask

  task automatic clear();
    sw_clear = 1'b1;
    @(negedge clk);
    sw_clear = 1'b0;
  endtask

  // Runs cycles 1..maxc after the strobe edge; returns first cycle with safe_off high.
  task automatic measure(input int maxc, input int ack_at, input int wr_at,
                         input logic [31:0] wr_val, input int tog_at, output int first);
    first = -1;
    for (int c = 1; c <= maxc; c++) begin
      ack_rcvd     = (c == ack_at);
      reg_wr       = (c == wr_at);
      reg_wdata    = wr_val;
      turnoff_sent = (c == tog_at);
      sw_clear     = (c == tog_at + 1);
      @(negedge clk);
      if (safe_off && first < 0) first = c;
    end
    ack_rcvd = 1'b0; reg_wr = 1'b0; turnoff_sent = 1'b0; sw_clear = 1'b0;
  endtask

  task automatic run_case(input int n, input int j);
    int first;
    int exp_first;
    bit exp_ack;
    wr_limit(n);
    strobe();
    check("R3", "waiting after strobe", waiting, 1);
    measure(n + 4, j, 0, '0, -5, first);
    exp_ack   = (j >= 1 && j <= n + 1);
    exp_first = exp_ack ? j : n + 1;
    if (j == n + 1)
      check("R6", "collision acked", st_acked, 1);
    else if (exp_ack)
      check("R5", "ack end cycle", first, exp_first);
    else
      check("R4", "timeout end cycle", first, exp_first);
    check(exp_ack ? "R5" : "R4", "status", {st_acked, st_timeout}, exp_ack ? 2 : 1);
    clear();
    check("R7", "clear to idle", {safe_off, st_acked, st_timeout, waiting}, 0);
  endtask

  task automatic run_all();
    int first;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "outputs after reset", {safe_off, st_acked, st_timeout, waiting}, 0);
    check("R1", "register after reset", reg_rdata, 0);

    // R2 reserved bits
    wr_limit(32'hFFFF_FFFF);
    check("R2", "all-ones readback", reg_rdata, 32'h003F_FFFF);
    wr_limit(32'hABC0_0005);
    check("R2", "reserved write ignored", reg_rdata, 5);

    // R9 ack while idle
    ack_rcvd = 1'b1; @(negedge clk); ack_rcvd = 1'b0; @(negedge clk);
    check("R9", "ack in idle", {safe_off, st_acked, st_timeout}, 0);

    // R4 timeout sweep, including zero
    for (int n = 0; n <= 12; n++) run_case(n, 0);
    // R5/R6 ack offset sweep
    for (int n = 0; n <= 5; n++)
      for (int j = 1; j <= n + 3; j++) run_case(n, j);

    // R9 ack in done, R7 hold
    wr_limit(2); strobe();
    measure(6, 0, 0, '0, -5, first);
    ack_rcvd = 1'b1; @(negedge clk); ack_rcvd = 1'b0;
    repeat (20) @(negedge clk);
    check("R9", "ack in done status", {st_acked, st_timeout}, 1);
    check("R7", "done holds safe", safe_off, 1);

    // R12 strobe and clear together in done
    turnoff_sent = 1'b1; sw_clear = 1'b1; @(negedge clk);
    turnoff_sent = 1'b0; sw_clear = 1'b0;
    check("R12", "restart wins over clear", {waiting, safe_off}, 2);
    measure(6, 0, 0, '0, -5, first);
    check("R12", "restarted wait end", first, 3);
    clear();

    // R10 write during wait
    wr_limit(10); strobe();
    measure(14, 0, 3, 32'd2, -5, first);
    check("R10", "wait keeps old count", first, 11);
    check("R10", "new count stored", reg_rdata, 2);
    clear(); strobe();
    measure(6, 0, 0, '0, -5, first);
    check("R10", "next wait uses new count", first, 3);
    clear();

    // R11 strobe and clear during wait
    wr_limit(8); strobe();
    measure(12, 0, 0, '0, 4, first);
    check("R11", "strobe/clear in wait ignored", first, 9);
    check("R11", "status timeout", {st_acked, st_timeout}, 1);
    clear();

    // R8 endpoint mode
    rc_mode = 1'b0; wr_limit(1); strobe();
    repeat (5) @(negedge clk);
    check("R8", "endpoint ignores strobe", {waiting, safe_off, st_acked, st_timeout}, 0);
    rc_mode = 1'b1;
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual %0d expected %0d", 1, 0);
      end
    join_any
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule